// File: doc/BRIEF.md
# Partial-Bank Address Remapper

This block reshapes a 40-bit physical address so that a memory controller can work with only part of its banks fitted. A shift amount moves the upper address field left by one or two places. The three bank-select bits 8:6 are not shifted along with that field. They are rebuilt from the incoming address. A 4-bit bank-set mask code can then force bit 7 or bit 8 high, force it low, or invert bit 7, so that traffic is steered away from banks that are not present.

The block sits directly in front of the hashing and DRAM field-decode logic. It offers an optional output register with a valid flag. The remapped address and a 2-bit bank-set select, taken from bits 8:7 of the result, are presented together.

Top module: `pba_remap`

## Requirements
- R1: With a shift of 0, the output address equals the input address and the mask code has no effect. A shift code of 3 is treated the same way.
- R2: With a shift of 1 or 2, output bits 6:0 equal input bits 6:0.
- R3: With a shift of 1 and a mask code that overrides nothing, output bits 8 and 7 both equal input bit 7. With a shift of 2 and such a code, both bits are 0.
- R4: With a shift of 1 or 2, output bits 39:9 equal bits 39:9 of the input shifted left by the shift amount, truncated to 40 bits. Input bits pushed above bit 39 are lost.
- R5: With a nonzero shift, mask codes 0x2 and 0xA set output bit 7 to 1, code 0x5 clears bit 7, and code 0x6 inverts the rebuilt bit 7. Bit 8 keeps its rebuilt value.
- R6: With a nonzero shift, mask code 0x3 clears output bit 8, and codes 0x4 and 0xC set bit 8 to 1. In all three cases bit 7 keeps its rebuilt value. Code 0x8 sets both bits 7 and 8 to 1.
- R7: Mask codes 0x0, 0x1, 0x7, 0x9, 0xB, 0xD, 0xE and 0xF leave the rebuilt bits 8:7 unchanged.
- R8: The bank-set select output always equals bits 8:7 of the output address.
- R9: With the output register present, the output valid equals the input valid of the previous cycle. The output address takes the remapped value one cycle after a valid input and holds it through invalid cycles. A synchronous reset clears both the valid and the address to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input address is valid |
| in_addr | input | 40 | Physical address to remap |
| shift_amt | input | 2 | Upper-field shift: 0, 1 or 2 (3 acts as 0) |
| mask_code | input | 4 | Bank-set mask code |
| out_valid | output | 1 | Remapped address is valid |
| out_addr | output | 40 | Remapped address |
| out_bank_sel | output | 2 | Bank-set select, bits 8:7 of out_addr |

## Verification
Every pairing of the four shift codes with all sixteen mask codes is applied to several addresses:
- all zeros, which shows whether a force-to-one code sets a bit from nothing;
- all ones, which shows clears and the discarding of bits shifted past bit 39;
- bit 7 alone, which separates the shift-1 copy of bit 7 from the shift-2 zero start and from inversion;
- a random value, which exercises the upper-field shift.

Invalid cycles placed between vectors show that the address register holds its value. A reset applied while valid input is present shows that the register is cleared.

// File: rtl/pba_pkg.sv
package pba_pkg;
    localparam int ADDR_W  = 40;
    localparam int SHIFT_W = 2;
    localparam int MASK_W  = 4;
    localparam int BANK_LO = 6;
    localparam int UPPER_LO = BANK_LO + 3;
    localparam int UPPER_W  = ADDR_W - UPPER_LO;

    typedef enum logic [MASK_W-1:0] {
        MC_SET7_A  = 4'h2,
        MC_CLR8    = 4'h3,
        MC_SET8_A  = 4'h4,
        MC_CLR7    = 4'h5,
        MC_INV7    = 4'h6,
        MC_SET78   = 4'h8,
        MC_SET7_B  = 4'hA,
        MC_SET8_B  = 4'hC
    } mask_code_e;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
    } out_rec_t;
endpackage

// File: rtl/pba_upper_shift.sv
module pba_upper_shift
    import pba_pkg::*;
(
    input  logic [ADDR_W-1:BANK_LO+1] addr_hi,
    input  logic [SHIFT_W-1:0]        shift_amt,
    output logic [UPPER_W-1:0]        upper
);
    always_comb begin
        case (shift_amt)
            2'd1:    upper = addr_hi[ADDR_W-2:UPPER_LO-1];
            2'd2:    upper = addr_hi[ADDR_W-3:UPPER_LO-2];
            default: upper = addr_hi[ADDR_W-1:UPPER_LO];
        endcase
    end
endmodule

// File: rtl/pba_bank_rebuild.sv
module pba_bank_rebuild
    import pba_pkg::*;
(
    input  logic              src_b7,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic [MASK_W-1:0]  mask_code,
    output logic [1:0]         bank_hi
);
    logic b7, b8;

    always_comb begin
        b7 = (shift_amt == 2'd1) ? src_b7 : 1'b0;
        b8 = b7;
        case (mask_code)
            MC_SET7_A, MC_SET7_B: b7 = 1'b1;
            MC_CLR7:              b7 = 1'b0;
            MC_INV7:              b7 = ~b7;
            MC_CLR8:              b8 = 1'b0;
            MC_SET8_A, MC_SET8_B: b8 = 1'b1;
            MC_SET78: begin
                b7 = 1'b1;
                b8 = 1'b1;
            end
            default: ;
        endcase
        bank_hi = {b8, b7};
    end
endmodule

// File: rtl/pba_out_stage.sv
module pba_out_stage
    import pba_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [ADDR_W-1:0] in_addr,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr
);
    generate
        if (REGISTER_OUT) begin : g_reg
            out_rec_t rec_d, rec_q;

            always_comb begin
                rec_d       = rec_q;
                rec_d.valid = in_valid;
                if (in_valid) begin
                    rec_d.addr = in_addr;
                end
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    rec_q <= '0;
                end else begin
                    rec_q <= rec_d;
                end
            end

            assign out_valid = rec_q.valid;
            assign out_addr  = rec_q.addr;
        end else begin : g_comb
            assign out_valid = in_valid;
            assign out_addr  = in_addr;
        end
    endgenerate
endmodule

// File: rtl/pba_remap.sv
module pba_remap
    import pba_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic [MASK_W-1:0]  mask_code,
    output logic               out_valid,
    output logic [ADDR_W-1:0]  out_addr,
    output logic [1:0]         out_bank_sel
);
    logic [UPPER_W-1:0] upper;
    logic [1:0]         bank_hi;
    logic [ADDR_W-1:0]  remap_d;
    logic               active;

    pba_upper_shift u_shift (
        .addr_hi   (in_addr[ADDR_W-1:BANK_LO+1]),
        .shift_amt (shift_amt),
        .upper     (upper)
    );

    pba_bank_rebuild u_bank (
        .src_b7    (in_addr[BANK_LO+1]),
        .shift_amt (shift_amt),
        .mask_code (mask_code),
        .bank_hi   (bank_hi)
    );

    always_comb begin
        active = (shift_amt == 2'd1) || (shift_amt == 2'd2);
        if (active) begin
            remap_d = {upper, bank_hi, in_addr[BANK_LO:0]};
        end else begin
            remap_d = in_addr;
        end
    end

    pba_out_stage #(.REGISTER_OUT(REGISTER_OUT)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_addr   (remap_d),
        .out_valid (out_valid),
        .out_addr  (out_addr)
    );

    assign out_bank_sel = out_addr[BANK_LO+2:BANK_LO+1];
endmodule

// File: rtl/pba_remap_chk.sv
module pba_remap_chk
    import pba_pkg::*;
#(
    parameter bit REGISTER_OUT = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [ADDR_W-1:0]  in_addr,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic [MASK_W-1:0]  mask_code,
    input  logic               out_valid,
    input  logic [ADDR_W-1:0]  out_addr,
    input  logic [1:0]         out_bank_sel
);
    generate
        if (REGISTER_OUT) begin : g_chk
            AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_addr == '0)); // R9
            AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) 1'b1 |=> out_valid == $past(in_valid)); // R9
            AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(out_addr)); // R9
            AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (shift_amt == 2'd0 || shift_amt == 2'd3)) |=> out_addr == $past(in_addr)); // R1
            AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
                (in_valid && (shift_amt == 2'd1 || shift_amt == 2'd2)) |=> out_addr[6:0] == $past(in_addr[6:0])); // R2
            AST_UPPER_SHIFT1: assert property (@(posedge clk) disable iff (rst)
                (in_valid && shift_amt == 2'd1) |=> out_addr[ADDR_W-1:9] == $past(in_addr[ADDR_W-2:8])); // R4
            AST_FORCE_BOTH: assert property (@(posedge clk) disable iff (rst)
                (in_valid && shift_amt == 2'd2 && mask_code == 4'h8) |=> out_bank_sel == 2'b11); // R6
            AST_SHIFT2_ZERO: assert property (@(posedge clk) disable iff (rst)
                (in_valid && shift_amt == 2'd2 && mask_code == 4'h0) |=> out_bank_sel == 2'b00); // R3
        end
    endgenerate
endmodule

bind pba_remap pba_remap_chk #(.REGISTER_OUT(REGISTER_OUT)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_addr      (in_addr),
    .shift_amt    (shift_amt),
    .mask_code    (mask_code),
    .out_valid    (out_valid),
    .out_addr     (out_addr),
    .out_bank_sel (out_bank_sel)
);

// File: tb/tb_pba_remap.sv
module tb_pba_remap;
    localparam longint unsigned M40 = 64'hFF_FFFF_FFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [39:0] in_addr = '0;
    logic [1:0]  shift_amt = '0;
    logic [3:0]  mask_code = '0;
    logic        out_valid;
    logic [39:0] out_addr;
    logic [1:0]  out_bank_sel;

    int errors = 0;
    int checks = 0;

    typedef struct {
        bit              v;
        longint unsigned a;
        int              sh;
        int              m;
    } exp_t;

    exp_t            pend[$];
    longint unsigned held = 0;

    pba_remap dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_addr(in_addr),
        .shift_amt(shift_amt), .mask_code(mask_code),
        .out_valid(out_valid), .out_addr(out_addr), .out_bank_sel(out_bank_sel)
    );

    always #2 clk = ~clk;

    function automatic longint unsigned model(longint unsigned a, int sh, int m);
        longint unsigned r;
        bit b7, b8;
        if (sh == 0 || sh == 3) return a;
        r  = ((a << sh) & M40) & ~64'h1FF;
        b7 = (sh == 1) ? a[7] : 1'b0;
        b8 = b7;
        case (m)
            2, 10: b7 = 1;
            5:     b7 = 0;
            6:     b7 = ~b7;
            3:     b8 = 0;
            4, 12: b8 = 1;
            8: begin b7 = 1; b8 = 1; end
            default: ;
        endcase
        r = r | (longint'(b8) << 8) | (longint'(b7) << 7) | (a & 64'h7F);
        return r;
    endfunction

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic compare_pending();
        exp_t e;
        string t87;
        if (pend.size() == 0) return;
        e = pend.pop_front();
        chk("R9 valid", longint'(out_valid), longint'(e.v));
        chk("R8 bank_sel", longint'(out_bank_sel), longint'(out_addr[8:7]));
        if (!e.v) begin
            chk("R9 hold", longint'(out_addr), e.a);
        end else if (e.sh == 0 || e.sh == 3) begin
            chk("R1 pass", longint'(out_addr), e.a);
        end else begin
            chk("R2 low", longint'(out_addr[6:0]), e.a & 64'h7F);
            chk("R4 upper", longint'(out_addr[39:9]), e.a >> 9);
            case (e.m)
                2, 5, 6, 10: t87 = "R5 bits87";
                3, 4, 8, 12: t87 = "R6 bits87";
                default:     t87 = "R3 R7 bits87";
            endcase
            chk(t87, longint'(out_addr[8:7]), (e.a >> 7) & 3);
        end
    endtask

    task automatic step(bit v, longint unsigned a, int sh, int m);
        exp_t e;
        @(negedge clk);
        compare_pending();
        in_valid  = v;
        in_addr   = a[39:0];
        shift_amt = sh[1:0];
        mask_code = m[3:0];
        if (v) held = model(a, sh, m);
        e.v = v; e.a = held; e.sh = sh; e.m = m;
        pend.push_back(e);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        longint unsigned pats[4];
        int n = 0;
        repeat (3) @(negedge clk);
        chk("R9 reset valid", longint'(out_valid), 0);
        chk("R9 reset addr", longint'(out_addr), 0);
        @(negedge clk);
        rst = 1'b0;
        pats[0] = 0;
        pats[1] = M40;
        pats[2] = 64'h80;
        for (int sh = 0; sh < 4; sh++) begin
            for (int m = 0; m < 16; m++) begin
                pats[3] = {$urandom, $urandom} & M40;
                for (int p = 0; p < 4; p++) begin
                    step(1'b1, pats[p], sh, m);
                    n++;
                    if (n % 5 == 0) step(1'b0, {$urandom, $urandom} & M40, sh, m);
                end
            end
        end
        step(1'b1, 64'h12_3456_789A, 1, 0);
        @(negedge clk);
        compare_pending();
        in_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        chk("R9 reset clears valid", longint'(out_valid), 0);
        chk("R9 reset clears addr", longint'(out_addr), 0);
        rst = 1'b0;
        in_valid = 1'b0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule